// File: doc/BRIEF.md
# Byte-to-Halfword Vector Load Packer

This block runs a unit-stride vector load in which every source element is one byte and every destination element is a halfword. For element index i, starting at zero, it reads the byte at address base+i and zero-extends it to 16 bits. It then writes the result into halfword slot i of a packed destination that starts at register RT of a 64-bit integer register file. The register file keeps little-endian byte order and never swaps bytes. The loaded byte therefore lands at the lower byte address of its slot and the zero pad at the next byte. Four elements fill one register, and element 4 starts at byte 0 of RT+1.

A start pulse in the idle state captures the base address, the destination register number, the vector length and the maximum vector length. The effective length is the vector length clamped to the maximum length, which is itself clamped to the build limit. Only elements below the effective length are written, and every other destination byte keeps its old value. Each element takes one read cycle and one write cycle. A one-cycle done pulse follows the last write.

Neither data port has back-pressure. The memory must return the byte in the cycle after the address is presented, and the register file must take a write in any cycle it is offered. Start is a plain level that is sampled only while the block is idle.

Top module: `vlp_unit`

## Requirements
- R1: After reset, `done`, `mem_rd_en` and `rf_we` are all low.
- R2: The block reads element i from address `base_addr`+i (modulo 2^ADDR_W), in increasing order of i, with exactly one read per active element.
- R3: Element i is written as the 16-bit value {8'h00, byte}: the loaded byte sits on data bits [16*(i%4)+7 : 16*(i%4)] and the bits above it, up to 16*(i%4)+15, are zero.
- R4: For element i, the write enables `rf_be` are exactly bits 2*(i%4) and 2*(i%4)+1.
- R5: Element i goes to register `dest_reg` + floor(i/4), modulo 2^REG_IDX_W.
- R6: Exactly VLeff writes take place. Every destination byte not covered by elements 0..VLeff-1 keeps its previous value, and `rf_be` is zero whenever `rf_we` is low.
- R7: A maximum length above the vector length does not change which bytes are written, or their values.
- R8: VLeff = min(`vl`, min(`maxvl`, MAXVL_LIM)), with MAXVL_LIM = 64 by default.
- R9: When VLeff is 0, the block makes no read and no write, and `done` is high in the cycle right after the start cycle.
- R10: The write of each element comes in the cycle right after its read and never in the same cycle as a read. With VLeff = n > 0, `done` is high exactly 2n+1 cycles after the start cycle and lasts one cycle.
- R11: A start asserted while the block is busy is ignored: it changes neither the running operation nor any later cycle, and it starts no further operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| dest_reg | input | REG_IDX_W | First destination register |
| vl | input | VL_W | Requested vector length |
| maxvl | input | VL_W | Maximum vector length |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Read byte, valid the cycle after `mem_rd_en` |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | REG_IDX_W | Register-file write index |
| rf_wdata | output | 64 | Write data (only enabled bytes are meaningful) |
| rf_be | output | 8 | Per-byte write enables |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory returns its byte exactly one cycle after each read strobe. They also assume that the register file accepts a write in any cycle, since the block applies no stall. The bench memory model is a registered lookup of a fixed address hash and is driven only after a strobe. The bench register-file model applies every offered write on the next edge. Start is driven on falling edges, either in the idle state or as a deliberate mid-run pulse that must be ignored. Lengths sweep 0 to 12 against several maximum lengths, including values above the build limit.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } vlp_state_e;
endpackage

// File: rtl/vlp_ctrl.sv
module vlp_ctrl
  import vlp_pkg::*;
#(
  parameter int MAXVL_LIM = 64,
  parameter int VL_W      = $clog2(MAXVL_LIM + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl,
  input  logic [VL_W-1:0] maxvl,
  output logic            accept,
  output logic            rd_en,
  output logic            wr_en,
  output logic            done,
  output logic [VL_W-1:0] idx
);
  localparam logic [VL_W-1:0] LIM_V = MAXVL_LIM[VL_W-1:0];

  vlp_state_e      state_q;
  logic [VL_W-1:0] idx_q;
  logic [VL_W-1:0] len_q;
  logic [VL_W-1:0] cap_c;
  logic [VL_W-1:0] len_c;
  logic            last_c;

  // Clamp the requested length to the maximum length, and that to the build limit.
  always_comb begin
    cap_c  = (maxvl > LIM_V) ? LIM_V : maxvl;
    len_c  = (vl > cap_c) ? cap_c : vl;
    last_c = ((idx_q + 1'b1) == len_q);
  end

  assign accept = start && (state_q == ST_IDLE);
  assign rd_en  = (state_q == ST_READ);
  assign wr_en  = (state_q == ST_WRITE);
  assign done   = (state_q == ST_DONE);
  assign idx    = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            len_q   <= len_c;
            idx_q   <= '0;
            state_q <= (len_c == '0) ? ST_DONE : ST_READ;
          end
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= last_c ? ST_DONE : ST_READ;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: the element index never reaches the captured length while busy
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> (idx_q < len_q));

  // R8: the captured length never exceeds the build limit
  p_len_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (len_q <= LIM_V));

  // R10: each read is followed by its write
  p_read_then_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);

  // R9: a zero length goes straight to done
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_IDLE) && ((vl == '0) || (maxvl == '0))) |=> done);

  // R11: the captured length is held while an operation runs
  p_len_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |=> (len_q == $past(len_q)));
endmodule

// File: rtl/vlp_lane_pack.sv
module vlp_lane_pack #(
  parameter int LANES  = 4,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  en,
  input  logic [LANE_W-1:0]     lane,
  input  logic [7:0]            byte_in,
  output logic [LANES*16-1:0]   wdata,
  output logic [LANES*2-1:0]    be
);
  // One zero-extended halfword slot per lane; the data byte sits at the low address.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit              = en && (lane == LANE_W'(g));
    assign wdata[g*16 +: 16] = hit ? {8'h00, byte_in} : 16'h0000;
    assign be[g*2 +: 2]      = {2{hit}};
  end
endmodule

// File: rtl/vlp_unit.sv
module vlp_unit #(
  parameter int ADDR_W    = 16,
  parameter int REG_IDX_W = 5,
  parameter int MAXVL_LIM = 64,
  parameter int VL_W      = $clog2(MAXVL_LIM + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic [REG_IDX_W-1:0] dest_reg,
  input  logic [VL_W-1:0]      vl,
  input  logic [VL_W-1:0]      maxvl,
  output logic                 mem_rd_en,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [7:0]           mem_rdata,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_addr,
  output logic [63:0]          rf_wdata,
  output logic [7:0]           rf_be,
  output logic                 done
);
  localparam int REG_BYTES = 8;
  localparam int LANES     = REG_BYTES / 2;
  localparam int LANE_W    = $clog2(LANES);
  localparam int DATA_W    = REG_BYTES * 8;

  function automatic logic [DATA_W-1:0] pad_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++) m[l*16+8 +: 8] = 8'hFF;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] PAD_MASK = pad_mask();

  logic                 accept;
  logic                 wr_en;
  logic [VL_W-1:0]      idx;
  logic [ADDR_W-1:0]    base_q;
  logic [REG_IDX_W-1:0] rt_q;

  vlp_ctrl #(.MAXVL_LIM(MAXVL_LIM), .VL_W(VL_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vl     (vl),
    .maxvl  (maxvl),
    .accept (accept),
    .rd_en  (mem_rd_en),
    .wr_en  (wr_en),
    .done   (done),
    .idx    (idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      rt_q   <= '0;
    end else if (accept) begin
      base_q <= base_addr;
      rt_q   <= dest_reg;
    end
  end

  assign mem_addr = base_q + ADDR_W'(idx);
  assign rf_addr  = rt_q + REG_IDX_W'(idx >> LANE_W);
  assign rf_we    = wr_en;

  vlp_lane_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
    .en      (wr_en),
    .lane    (idx[LANE_W-1:0]),
    .byte_in (mem_rdata),
    .wdata   (rf_wdata),
    .be      (rf_be)
  );

  // R4: an element write enables exactly one two-byte lane
  p_be_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($countones(rf_be) == 2));

  // R6: no byte enable without a write
  p_be_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_we |-> (rf_be == '0));

  // R3: the pad byte of every lane is zero on a write
  p_zero_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((rf_wdata & PAD_MASK) == '0));

  // R10: reads and writes never share a cycle
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && rf_we));

  // R9: done is a quiet cycle
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd_en && !rf_we));

  // R2: consecutive reads of one operation step the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(rf_we)) |-> (mem_addr == ADDR_W'($past(mem_addr, 2) + 1'b1)));
endmodule

// File: tb/tb_vlp_unit.sv
module tb_vlp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int RIW    = 5;
  localparam int NREG   = 32;
  localparam int VL_W   = 7;
  localparam int LIM    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [RIW-1:0] dest_reg = '0;
  logic [VL_W-1:0] vl = '0, maxvl = '0;
  logic mem_rd_en, rf_we, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [RIW-1:0] rf_addr;
  logic [63:0] rf_wdata;
  logic [7:0] rf_be;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlp_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .dest_reg(dest_reg), .vl(vl), .maxvl(maxvl), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_be(rf_be), .done(done)
  );

  function automatic logic [7:0] fbyte(logic [ADDR_W-1:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h5A;
  endfunction

  function automatic logic [63:0] init_word(int r);
    return 64'h0123_4567_89AB_CDEF ^ {8{8'(r * 7 + 1)}};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model: registered byte one cycle after the strobe
  always @(posedge clk) if (mem_rd_en) mem_rdata <= fbyte(mem_addr);

  // Register-file model
  logic [63:0] rf_m [NREG];
  logic init_req = 1'b0;
  always @(posedge clk) begin
    if (init_req) begin
      for (int r = 0; r < NREG; r++) rf_m[r] <= init_word(r);
    end else if (rf_we) begin
      for (int b = 0; b < 8; b++)
        if (rf_be[b]) rf_m[rf_addr][b*8 +: 8] <= rf_wdata[b*8 +: 8];
    end
  end

  // Per-cycle monitor of the ports, sampled on falling edges
  logic [ADDR_W-1:0] cur_base = '0;
  int cur_rt = 0;
  int nrd = 0, nwr = 0;
  always @(negedge clk) begin
    if (rst_n && mem_rd_en) begin
      check(mem_addr == ADDR_W'(int'(cur_base) + nrd), "R2", "read address",
            mem_addr, ADDR_W'(int'(cur_base) + nrd));
      nrd++;
    end
    if (rst_n && rf_we) begin
      automatic int i = nwr;
      automatic logic [RIW-1:0] ea = RIW'(cur_rt + i / 4);
      automatic logic [7:0] eb = 8'b11 << (2 * (i % 4));
      automatic logic [15:0] hw = rf_wdata[16*(i%4) +: 16];
      automatic logic [15:0] eh = {8'h00, fbyte(ADDR_W'(int'(cur_base) + i))};
      check(rf_addr == ea, "R5", "register index", rf_addr, ea);
      check(rf_be == eb, "R4", "byte enables", rf_be, eb);
      check(hw == eh, "R3", "halfword data", hw, eh);
      nwr++;
    end
  end

  task automatic run_op(int b, int rt, int v, int m, bit inject, string req);
    automatic int cap = (m > LIM) ? LIM : m;
    automatic int e = (v > cap) ? cap : v;
    automatic int cyc;
    automatic logic [63:0] exp_img [NREG];
    automatic int bad = 0, bad_r = -1;
    @(negedge clk);
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    nrd = 0; nwr = 0;
    cur_base = ADDR_W'(b); cur_rt = rt;
    base_addr = ADDR_W'(b); dest_reg = RIW'(rt);
    vl = VL_W'(v); maxvl = VL_W'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 1000) begin
      if (inject && cyc == 2) begin
        start = 1'b1; base_addr = ~ADDR_W'(b); dest_reg = RIW'(rt + 9);
        vl = 7'd3; maxvl = 7'd3;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (e == 0) check(cyc == 1, "R9", "done latency for zero length", cyc, 1);
    else check(cyc == 2 * e + 1, "R10", "done latency", cyc, 2 * e + 1);
    check(nrd == e, inject ? "R11" : "R2", "read count", nrd, e);
    check(nwr == e, req, "write count", nwr, e);
    for (int r = 0; r < NREG; r++) exp_img[r] = init_word(r);
    for (int i = 0; i < e; i++) begin
      automatic int rr = (rt + i / 4) % NREG;
      exp_img[rr][16*(i%4) +: 16] = {8'h00, fbyte(ADDR_W'(b + i))};
    end
    @(negedge clk);
    check(!done, "R10", "done lasts one cycle", done, 0);
    for (int r = 0; r < NREG; r++)
      if (rf_m[r] !== exp_img[r]) begin bad++; if (bad_r < 0) bad_r = r; end
    if (bad_r < 0) check(1'b1, req, "register image", 0, 0);
    else check(1'b0, req, $sformatf("register image r%0d", bad_r), rf_m[bad_r], exp_img[bad_r]);
    if (inject) begin
      automatic int extra = 0;
      repeat (6) begin @(negedge clk); if (mem_rd_en || rf_we || done) extra++; end
      check(extra == 0, "R11", "no operation after ignored start", extra, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    automatic int mlist [8] = '{0, 2, 3, 4, 7, 12, 64, 100};
    repeat (3) @(negedge clk);
    check(!done && !mem_rd_en && !rf_we, "R1", "idle outputs in reset", {done, mem_rd_en, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_rd_en && !rf_we, "R1", "idle outputs after reset", {done, mem_rd_en, rf_we}, 0);

    // Sweep length against maximum length (R6, R7, R8, R9)
    for (int v = 0; v <= 12; v++)
      for (int k = 0; k < 8; k++) begin
        automatic int m = mlist[k];
        automatic string rq = (m < v) ? "R8" : ((m > v) ? "R7" : "R6");
        run_op(16'h0100 * k + v * 3, (v * 5 + k * 3) % NREG, v, m, 1'b0, rq);
      end
    // Same length, different maximum lengths: identical layout (R7)
    run_op(16'h4000, 2, 3, 3, 1'b0, "R7");
    run_op(16'h4000, 2, 3, 4, 1'b0, "R7");
    run_op(16'h4000, 2, 7, 7, 1'b0, "R6");
    // Full length, register and address wrap (R5, R8)
    run_op(16'hFFF0, 30, 64, 64, 1'b0, "R5");
    run_op(16'h1234, 0, 127, 127, 1'b0, "R8");
    run_op(16'h0042, 17, 70, 65, 1'b0, "R8");
    // Start while busy is ignored (R11)
    run_op(16'h0800, 6, 6, 8, 1'b1, "R11");
    run_op(16'h0900, 31, 1, 5, 1'b1, "R11");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule